// File: doc/BRIEF.md
# Circular Audio Playback Fetch Engine

This block reads multichannel PCM sample words from a ring buffer in memory and hands them, one sample at a time, to a serial audio output stage. Software programs the ring through a small word-addressed register port: a base pointer, a pointer to the last valid burst, a live read pointer, a mask word holding the period length in bursts plus two channel-select fields, and a control word with init, fill-enable, drain-enable and 16-bit packing bits.

Once the fill enable is set, the engine watches its sample FIFO. Whenever the FIFO holds fewer than half its capacity, it fetches one fixed-size burst (256 bytes by default) as consecutive single-word reads on a valid/ready request port with an in-order response port. After the burst at the last-burst pointer it returns to the base pointer. The consumer pulls samples with a strobe. In 16-bit mode each memory word yields two samples. A period interrupt pulses once every programmed number of completed bursts. Pulling from an empty FIFO returns silence and records an underrun.

Typical use: write the pointers and mask word, pulse the init bits, then set both enables to play and clear them to pause. The read pointer can be read at any time to learn the playback position.

Top module: `audio_ring_reader`

## Requirements
- R1: After reset every register reads 0, `irq` and `mem_req_valid` are low and `smp_data` is 0.
- R2: Register index (reg_addr) 0 is control: bit 0 init, bit 1 fill enable, bit 2 drain enable, bit 6 16-bit packing, bit 7 busy (read-only), bit 8 data-ready (read-only). Index 1 is buffer control with init at bit 0. Index 2 is the base pointer, 3 the read pointer, 4 the last-burst pointer, 5 the mask word (period count in bits 31:16, memory channels in 15:8, read channels in 7:0) and 6 status. Written values read back unchanged.
- R3: While fill enable is set, neither init bit is set, no burst is in flight and the FIFO holds fewer than half its capacity, the engine starts a burst. A burst is BURST_BYTES/4 word reads at read pointer + 4·i for i = 0 upward. With fill enable clear, no burst starts.
- R4: When the last response of a burst arrives, the read pointer becomes the base pointer if the burst began at the last-burst pointer. Otherwise it grows by BURST_BYTES.
- R5: In 32-bit mode each pull returns the next fetched word unchanged, in memory address order.
- R6: In 16-bit mode each word yields two samples, the low half first, each zero-extended to 32 bits.
- R7: With drain enable clear, `smp_data` is 0 and pulls consume nothing.
- R8: A pull with drain enable set and an empty FIFO returns 0 and sets status bit 1. Writing 1 to that bit clears it.
- R9: A block counter counts completed bursts. When it reaches the period count (mask bits 31:16), it restarts at zero, `irq` is high for exactly one cycle and status bit 0 is set (cleared by writing 1). A period count of 0 never interrupts.
- R10: While either init bit is set, the read pointer is reloaded from the base pointer, the FIFO is emptied and the block counter and any in-flight burst state are cleared.
- R11: Control bit 7 reads 1 from burst start until its last response. Bit 8 reads 1 whenever the FIFO holds at least one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address of requested word |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| smp_pull | input | 1 | Consumer takes the current sample |
| smp_data | output | 32 | Current sample, 0 when none |
| irq | output | 1 | Period interrupt pulse |

## Verification
The properties assume that memory returns exactly one response per accepted request, in request order. They also assume that software leaves the pointers and init bits alone while a burst is in flight, and that pointers are aligned to the burst size. The stimulus respects this. The memory model answers only from its queue of accepted addresses. Every pointer or init change is made only after control bit 7 reads 0. Stalls are injected by holding back responses, never by dropping or reordering them.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BLK_W  = 16;

  typedef enum logic [2:0] {
    RI_CTRL   = 3'd0,
    RI_BUFCTL = 3'd1,
    RI_START  = 3'd2,
    RI_RDPTR  = 3'd3,
    RI_END    = 3'd4,
    RI_MASKS  = 3'd5,
    RI_STATUS = 3'd6
  } reg_idx_e;

  localparam int CB_INIT  = 0;
  localparam int CB_FILL  = 1;
  localparam int CB_EMPTY = 2;
  localparam int CB_HALF  = 6;
  localparam int CB_BUSY  = 7;
  localparam int CB_READY = 8;

  // Base address of the burst following the one at cur.
  function automatic logic [ADDR_W-1:0] next_base(
    input logic [ADDR_W-1:0] cur,
    input logic [ADDR_W-1:0] first,
    input logic [ADDR_W-1:0] last,
    input logic [ADDR_W-1:0] step
  );
    return (cur == last) ? first : cur + step;
  endfunction

  // Sample selected from one memory word.
  function automatic logic [DATA_W-1:0] unpack(
    input logic [DATA_W-1:0] word,
    input logic              half_mode,
    input logic              upper
  );
    if (!half_mode) return word;
    return upper ? {{(DATA_W/2){1'b0}}, word[DATA_W-1:DATA_W/2]}
                 : {{(DATA_W/2){1'b0}}, word[DATA_W/2-1:0]};
  endfunction
endpackage

// File: rtl/ring_regs.sv
module ring_regs
  import ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [ADDR_W-1:0] rdptr,
  input  logic              busy,
  input  logic              data_ready,
  input  logic              blk_hit,
  input  logic              underrun_evt,
  output logic              init,
  output logic              fill_en,
  output logic              empty_en,
  output logic              mode16,
  output logic [ADDR_W-1:0] start_ptr,
  output logic [ADDR_W-1:0] end_ptr,
  output logic [BLK_W-1:0]  blk_cfg,
  output logic              ptr_we,
  output logic [ADDR_W-1:0] ptr_wdata
);
  logic        ctl_init_q, ctl_fill_q, ctl_empty_q, ctl_half_q, buf_init_q;
  logic [31:0] masks_q;
  logic        st_irq_q, st_urun_q;
  logic [ADDR_W-1:0] start_q, end_q;

  logic wr_ctrl, wr_buf, wr_start, wr_end, wr_masks, wr_stat;
  assign wr_ctrl  = reg_we && (reg_addr == RI_CTRL);
  assign wr_buf   = reg_we && (reg_addr == RI_BUFCTL);
  assign wr_start = reg_we && (reg_addr == RI_START);
  assign wr_end   = reg_we && (reg_addr == RI_END);
  assign wr_masks = reg_we && (reg_addr == RI_MASKS);
  assign wr_stat  = reg_we && (reg_addr == RI_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_init_q  <= 1'b0;
      ctl_fill_q  <= 1'b0;
      ctl_empty_q <= 1'b0;
      ctl_half_q  <= 1'b0;
      buf_init_q  <= 1'b0;
      start_q     <= '0;
      end_q       <= '0;
      masks_q     <= '0;
      st_irq_q    <= 1'b0;
      st_urun_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctl_init_q  <= reg_wdata[CB_INIT];
        ctl_fill_q  <= reg_wdata[CB_FILL];
        ctl_empty_q <= reg_wdata[CB_EMPTY];
        ctl_half_q  <= reg_wdata[CB_HALF];
      end
      if (wr_buf)   buf_init_q <= reg_wdata[0];
      if (wr_start) start_q    <= reg_wdata;
      if (wr_end)   end_q      <= reg_wdata;
      if (wr_masks) masks_q    <= reg_wdata;
      st_irq_q  <= blk_hit      | (st_irq_q  & ~(wr_stat & reg_wdata[0]));
      st_urun_q <= underrun_evt | (st_urun_q & ~(wr_stat & reg_wdata[1]));
    end
  end

  assign init      = ctl_init_q | buf_init_q;
  assign fill_en   = ctl_fill_q;
  assign empty_en  = ctl_empty_q;
  assign mode16    = ctl_half_q;
  assign start_ptr = start_q;
  assign end_ptr   = end_q;
  assign blk_cfg   = masks_q[31:16];
  assign ptr_we    = reg_we && (reg_addr == RI_RDPTR);
  assign ptr_wdata = reg_wdata;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RI_CTRL: begin
        reg_rdata[CB_INIT]  = ctl_init_q;
        reg_rdata[CB_FILL]  = ctl_fill_q;
        reg_rdata[CB_EMPTY] = ctl_empty_q;
        reg_rdata[CB_HALF]  = ctl_half_q;
        reg_rdata[CB_BUSY]  = busy;
        reg_rdata[CB_READY] = data_ready;
      end
      RI_BUFCTL: reg_rdata[0] = buf_init_q;
      RI_START:  reg_rdata    = start_q;
      RI_RDPTR:  reg_rdata    = rdptr;
      RI_END:    reg_rdata    = end_q;
      RI_MASKS:  reg_rdata    = masks_q;
      RI_STATUS: reg_rdata    = {30'd0, st_urun_q, st_irq_q};
      default:   reg_rdata    = '0;
    endcase
  end
endmodule

// File: rtl/ring_fetch.sv
module ring_fetch
  import ring_pkg::*;
#(
  parameter int unsigned BURST_BYTES = 256,
  parameter int unsigned LVL_W       = 8,
  parameter int unsigned START_BELOW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              fill_en,
  input  logic [LVL_W-1:0]  level,
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic [ADDR_W-1:0] end_ptr,
  input  logic              ptr_we,
  input  logic [ADDR_W-1:0] ptr_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              push,
  output logic              busy,
  output logic              burst_start,
  output logic              burst_done,
  output logic [ADDR_W-1:0] rdptr
);
  localparam int unsigned WORDS = BURST_BYTES / (DATA_W / 8);
  localparam int unsigned CNT_W = $clog2(WORDS + 1);
  localparam logic [CNT_W-1:0]  CNT_ALL  = CNT_W'(WORDS);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(WORDS - 1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BURST_BYTES);

  logic              busy_q;
  logic [CNT_W-1:0]  issued_q, recv_q;
  logic [ADDR_W-1:0] rdptr_q;

  assign burst_start   = !busy_q && fill_en && !init && (level < LVL_W'(START_BELOW));
  assign mem_req_valid = busy_q && (issued_q != CNT_ALL);
  assign mem_req_addr  = rdptr_q + (ADDR_W'(issued_q) << 2);
  assign push          = busy_q && mem_rsp_valid;
  assign burst_done    = push && (recv_q == CNT_LAST);
  assign busy          = busy_q;
  assign rdptr         = rdptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      issued_q <= '0;
      recv_q   <= '0;
      rdptr_q  <= '0;
    end else if (init) begin
      busy_q   <= 1'b0;
      issued_q <= '0;
      recv_q   <= '0;
      rdptr_q  <= start_ptr;
    end else begin
      if (ptr_we) rdptr_q <= ptr_wdata;
      if (burst_start) begin
        busy_q   <= 1'b1;
        issued_q <= '0;
        recv_q   <= '0;
      end
      if (mem_req_valid && mem_req_ready) issued_q <= issued_q + 1'b1;
      if (push) recv_q <= recv_q + 1'b1;
      if (burst_done) begin
        busy_q  <= 1'b0;
        rdptr_q <= next_base(rdptr_q, start_ptr, end_ptr, STEP);
      end
    end
  end
endmodule

// File: rtl/ring_sample_out.sv
module ring_sample_out
  import ring_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pull,
  input  logic              empty_en,
  input  logic              mode16,
  output logic [DATA_W-1:0] smp_data,
  output logic              underrun_evt,
  output logic              not_empty,
  output logic [LVL_W-1:0]  level
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              upper_q;
  logic              take, pop;

  assign not_empty    = (lvl_q != '0);
  assign take         = pull && empty_en && not_empty;
  assign pop          = take && (!mode16 || upper_q);
  assign underrun_evt = pull && empty_en && !not_empty;
  assign level        = lvl_q;
  assign smp_data     = (empty_en && not_empty) ? unpack(store[rd_q], mode16, upper_q) : '0;

  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      lvl_q   <= '0;
      upper_q <= 1'b0;
    end else if (flush) begin
      wr_q    <= '0;
      rd_q    <= '0;
      lvl_q   <= '0;
      upper_q <= 1'b0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
      if (take && mode16) upper_q <= !upper_q;
      case ({push, pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/ring_blockirq.sv
module ring_blockirq
  import ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             burst_done,
  input  logic [BLK_W-1:0] blk_cfg,
  output logic             blk_hit,
  output logic             irq
);
  logic [BLK_W-1:0] cnt_q;
  logic             irq_q;

  assign blk_hit = burst_done && (blk_cfg != '0) && ((cnt_q + 1'b1) == blk_cfg);
  assign irq     = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (init) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= blk_hit;
      if (burst_done) begin
        if (blk_cfg == '0 || blk_hit) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_ring_reader.sv
module audio_ring_reader
  import ring_pkg::*;
#(
  parameter int unsigned BURST_BYTES = 256,
  parameter int unsigned FIFO_WORDS  = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        smp_pull,
  output logic [31:0] smp_data,
  output logic        irq
);
  localparam int unsigned LVL_W = $clog2(FIFO_WORDS + 1);
  localparam int unsigned HALF  = FIFO_WORDS / 2;

  logic              init, fill_en, empty_en, mode16;
  logic [ADDR_W-1:0] start_ptr, end_ptr, rdptr, ptr_wdata;
  logic [BLK_W-1:0]  blk_cfg;
  logic              ptr_we, busy, data_ready, blk_hit, underrun_evt;
  logic              push, burst_start, burst_done;
  logic [LVL_W-1:0]  level;

  ring_regs u_regs (
    .clk, .rst_n, .reg_addr, .reg_we, .reg_wdata, .reg_rdata,
    .rdptr, .busy, .data_ready, .blk_hit, .underrun_evt,
    .init, .fill_en, .empty_en, .mode16, .start_ptr, .end_ptr,
    .blk_cfg, .ptr_we, .ptr_wdata
  );

  ring_fetch #(.BURST_BYTES(BURST_BYTES), .LVL_W(LVL_W), .START_BELOW(HALF)) u_fetch (
    .clk, .rst_n, .init, .fill_en, .level, .start_ptr, .end_ptr,
    .ptr_we, .ptr_wdata, .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .push, .busy, .burst_start, .burst_done, .rdptr
  );

  ring_sample_out #(.DEPTH(FIFO_WORDS), .LVL_W(LVL_W)) u_out (
    .clk, .rst_n, .flush(init), .push, .push_data(mem_rsp_data),
    .pull(smp_pull), .empty_en, .mode16, .smp_data, .underrun_evt,
    .not_empty(data_ready), .level
  );

  ring_blockirq u_irq (
    .clk, .rst_n, .init, .burst_done, .blk_cfg, .blk_hit, .irq
  );
endmodule

// File: rtl/ring_reader_chk.sv
module ring_reader_chk #(
  parameter int unsigned BURST_BYTES = 256,
  parameter int unsigned FIFO_WORDS  = 128,
  parameter int unsigned LVL_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             init,
  input logic             fill_en,
  input logic             empty_en,
  input logic             burst_start,
  input logic             burst_done,
  input logic             push,
  input logic [LVL_W-1:0] level,
  input logic [31:0]      rdptr,
  input logic [31:0]      start_ptr,
  input logic             mem_req_valid,
  input logic [31:0]      mem_req_addr,
  input logic             smp_pull,
  input logic [31:0]      smp_data
);
  localparam logic [31:0] STEP = 32'(BURST_BYTES);

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);  // R9
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> (fill_en && !init && level < LVL_W'(FIFO_WORDS / 2)));  // R3
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));  // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (level < LVL_W'(FIFO_WORDS)));  // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && !init) |=> (rdptr == start_ptr || rdptr == $past(rdptr) + STEP));  // R4
  AST_DRAIN_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_en |-> (smp_data == 32'd0));  // R7
  AST_UNDERRUN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_pull && level == '0) |-> (smp_data == 32'd0));  // R8
  AST_INIT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (level == '0));  // R10
endmodule

bind audio_ring_reader ring_reader_chk #(
  .BURST_BYTES(BURST_BYTES), .FIFO_WORDS(FIFO_WORDS), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .init(init), .fill_en(fill_en),
  .empty_en(empty_en), .burst_start(burst_start), .burst_done(burst_done),
  .push(push), .level(level), .rdptr(rdptr), .start_ptr(start_ptr),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .smp_pull(smp_pull), .smp_data(smp_data)
);

// File: tb/audio_ring_reader_test.sv
`timescale 1ns/1ps
module audio_ring_reader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        smp_pull = 1'b0;
  logic [31:0] smp_data;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  int rsp_total = 0, irq_cnt = 0, irq_wide = 0, req_total = 0;
  bit stall = 1'b0;
  bit irq_prev = 1'b0;
  logic [31:0] pend[$];

  localparam logic [31:0] BASE = 32'h0000_1000;

  always #2.5 clk = ~clk;

  audio_ring_reader uut (
    .clk, .rst_n, .reg_addr, .reg_we, .reg_wdata, .reg_rdata,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid,
    .mem_rsp_data, .smp_pull, .smp_data, .irq
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h0101};
  endfunction

  // memory model: in-order responses, one per accepted request
  initial begin
    forever begin
      @(negedge clk);
      if (!stall && pend.size() > 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(pend.pop_front());
        rsp_total++;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      if (rst_n && mem_req_valid && mem_req_ready) begin
        pend.push_back(mem_req_addr);
        req_total++;
      end
      if (irq) irq_cnt++;
      if (irq && irq_prev) irq_wide++;
      irq_prev = irq;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4000; i++) begin
      reg_rd(3'd0, c);
      if (!c[7]) break;
    end
  endtask

  task automatic init_pulse();
    reg_wr(3'd0, 32'h1);
    reg_wr(3'd1, 32'h1);
    reg_wr(3'd0, 32'h0);
    reg_wr(3'd1, 32'h0);
  endtask

  task automatic setup(input logic [31:0] base, input logic [31:0] last, input logic [15:0] period);
    reg_wr(3'd2, base);
    reg_wr(3'd3, base);
    reg_wr(3'd4, last);
    reg_wr(3'd5, {period, 8'hFF, 8'hFF});
    init_pulse();
    rsp_total = 0; irq_cnt = 0; irq_wide = 0; req_total = 0;
  endtask

  task automatic pull_one(output logic [31:0] d);
    @(negedge clk);
    smp_pull = 1'b1;
    #1 d = smp_data;
    @(negedge clk);
    smp_pull = 1'b0;
  endtask

  task automatic wait_ready();
    logic [31:0] c;
    for (int i = 0; i < 2000; i++) begin
      reg_rd(3'd0, c);
      if (c[8]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int r = 0; r < 7; r++) begin
      reg_rd(3'(r), v);
      check("R1 register reset", v, 32'd0);
    end
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 req", {31'd0, mem_req_valid}, 32'd0);
    check("R1 sample", smp_data, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    reg_wr(3'd2, 32'hA5A5_0100); reg_rd(3'd2, v); check("R2 base", v, 32'hA5A5_0100);
    reg_wr(3'd4, 32'h0000_3F00); reg_rd(3'd4, v); check("R2 last", v, 32'h0000_3F00);
    reg_wr(3'd5, 32'h0007_FFFF); reg_rd(3'd5, v); check("R2 masks", v, 32'h0007_FFFF);
    reg_wr(3'd3, 32'h0000_2200); reg_rd(3'd3, v); check("R2 rdptr", v, 32'h0000_2200);
    reg_wr(3'd0, 32'h40);        reg_rd(3'd0, v); check("R2 ctrl", v, 32'h40);
    reg_wr(3'd0, 32'h0);
  endtask

  task automatic t_pointer();
    logic [31:0] v;
    // fill disabled: nothing fetched
    setup(32'h2000, 32'h2000, 16'd0);
    repeat (40) @(negedge clk);
    check("R3 no fetch without fill", 32'(req_total), 32'd0);
    // single-burst ring wraps to base
    reg_wr(3'd0, 32'h2);
    wait_idle();
    check("R3 burst word count", 32'(rsp_total), 32'd64);
    reg_rd(3'd3, v); check("R4 wrap at last", v, 32'h2000);
    reg_rd(3'd0, v); check("R11 ready after fill", {31'd0, v[8]}, 32'd1);
    reg_wr(3'd0, 32'h0);
    // two-burst ring advances
    setup(32'h2000, 32'h2100, 16'd0);
    reg_wr(3'd0, 32'h2);
    wait_idle();
    reg_rd(3'd3, v); check("R4 advance", v, 32'h2100);
    reg_wr(3'd0, 32'h0);
  endtask

  task automatic t_stream32();
    logic [31:0] d, v;
    int bad = 0;
    setup(BASE, BASE + 32'h100, 16'd1);
    reg_wr(3'd0, 32'h6);
    wait_ready();
    for (int k = 0; k < 300; k++) begin
      pull_one(d);
      if (d !== mem_word(BASE + ((32'(k) * 4) % 512))) bad++;
      repeat (2) @(negedge clk);
    end
    check("R5 32-bit order mismatches", 32'(bad), 32'd0);
    reg_wr(3'd0, 32'h0);
    wait_idle();
    reg_rd(3'd3, v);
    check("R4 position after stream", v, BASE + 32'((rsp_total / 64) % 2) * 32'h100);
    check("R9 irq each burst", 32'(irq_cnt), 32'(rsp_total / 64));
    check("R9 irq width", 32'(irq_wide), 32'd0);
  endtask

  task automatic t_stream16();
    logic [31:0] d, w;
    int bad = 0;
    setup(BASE, BASE + 32'h100, 16'd0);
    reg_wr(3'd0, 32'h46);
    wait_ready();
    for (int j = 0; j < 200; j++) begin
      pull_one(d);
      w = mem_word(BASE + ((32'(j / 2) * 4) % 512));
      if (d !== ((j % 2) ? {16'd0, w[31:16]} : {16'd0, w[15:0]})) bad++;
      repeat (2) @(negedge clk);
    end
    check("R6 16-bit unpack mismatches", 32'(bad), 32'd0);
    reg_wr(3'd0, 32'h0);
    wait_idle();
    check("R9 period zero silent", 32'(irq_cnt), 32'd0);
  endtask

  task automatic t_period3();
    logic [31:0] d, v;
    setup(BASE, BASE + 32'h100, 16'd3);
    reg_wr(3'd0, 32'h6);
    wait_ready();
    for (int k = 0; k < 450; k++) begin
      pull_one(d);
      @(negedge clk);
    end
    reg_wr(3'd0, 32'h0);
    wait_idle();
    check("R9 irq every third burst", 32'(irq_cnt), 32'(rsp_total / 192));
    reg_rd(3'd6, v); check("R9 sticky set", {31'd0, v[0]}, 32'd1);
    reg_wr(3'd6, 32'h1);
    reg_rd(3'd6, v); check("R9 sticky cleared", {31'd0, v[0]}, 32'd0);
  endtask

  task automatic t_underrun();
    logic [31:0] d, v;
    stall = 1'b1;
    setup(BASE, BASE + 32'h100, 16'd0);
    reg_wr(3'd0, 32'h6);
    repeat (10) @(negedge clk);
    reg_rd(3'd0, v);
    check("R11 busy while waiting", {31'd0, v[7]}, 32'd1);
    check("R11 not ready while empty", {31'd0, v[8]}, 32'd0);
    pull_one(d);
    check("R8 silence on empty", d, 32'd0);
    reg_rd(3'd6, v); check("R8 underrun flag", {31'd0, v[1]}, 32'd1);
    reg_wr(3'd6, 32'h2);
    reg_rd(3'd6, v); check("R8 underrun cleared", {31'd0, v[1]}, 32'd0);
    stall = 1'b0;
    wait_idle();
    pull_one(d);
    check("R8 first word intact", d, mem_word(BASE));
    reg_wr(3'd0, 32'h0);
  endtask

  task automatic t_drain_off();
    logic [31:0] d;
    setup(BASE, BASE + 32'h100, 16'd0);
    reg_wr(3'd0, 32'h2);
    wait_idle();
    for (int i = 0; i < 5; i++) pull_one(d);
    check("R7 silent when drain off", d, 32'd0);
    reg_wr(3'd0, 32'h4);
    pull_one(d);
    check("R7 pulls consumed nothing", d, mem_word(BASE));
    reg_wr(3'd0, 32'h0);
  endtask

  task automatic t_init();
    logic [31:0] v;
    setup(BASE, BASE + 32'h100, 16'd2);
    reg_wr(3'd0, 32'h2);
    wait_idle();
    reg_rd(3'd3, v); check("R10 moved before init", v, BASE + 32'h100);
    reg_wr(3'd0, 32'h0);
    init_pulse();
    reg_rd(3'd3, v); check("R10 rdptr reloaded", v, BASE);
    reg_rd(3'd0, v); check("R10 fifo flushed", {31'd0, v[8]}, 32'd0);
    reg_wr(3'd0, 32'h2);
    wait_idle();
    check("R10 block count cleared", 32'(irq_cnt), 32'd0);
    reg_wr(3'd0, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_pointer();
    t_stream32();
    t_stream16();
    t_period3();
    t_underrun();
    t_drain_off();
    t_init();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired before completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule